// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

The block is the device-side command interpreter of a 16-bit NOR flash. It watches the write cycles that a host places on the flash bus (a one-clock write strobe with its address and data) and turns valid multi-cycle sequences into requests for the embedded algorithms. It handles standard program, sector erase with a multi-sector acceptance window, chip erase, identifier reads, a fast program mode that skips the unlock cycles, and suspend and resume of a sector erase. An algorithm model outside the block raises a one-cycle done input when a program or erase finishes.

Command codes are taken from the low data byte. Unlock cycles are checked on the low 11 address bits (555h and 2AAh). The array is split into equal sectors, and the sector number is the top `SECT_BITS` bits of the word address. The block drives a read-source select, a program request with its latched address and data, an erase request with a sector mask, and single-cycle suspend and resume pulses. In identifier mode it also supplies the identifier word for the current read address.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Writing 555h/AAh, 2AAh/55h, 555h/A0h and then an address and data raises `prog_req` for one cycle, in the cycle after the fourth write, with `prog_addr`/`prog_data` equal to that fourth write. From then until `alg_done`, `rd_sel` is 2 (status). After `alg_done`, `rd_sel` returns to 0 (array).
- R2: A wrong address or wrong data in any unlock or setup cycle returns the decoder to its idle state without any request. A later correct sequence then works normally.
- R3: Writing 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h and then data 30h opens the erase window at once (`window_open`=1, `rd_sel`=2), with the mask holding the one-hot sector of the sixth address. When `WIN_CYC` cycles pass with no further write, `erase_req` pulses with that mask and the window closes.
- R4: The same six cycles with 10h last raise `erase_req` at once, with `erase_chip`=1 and every mask bit set. Data B0h written during a chip erase is ignored.
- R5: While the window is open, a 30h write adds the sector of its address to the mask and restarts the window. Any other write except B0h closes the window, clears the mask, returns to array read and produces no erase request.
- R6: B0h during the window or during a sector erase gives one `suspend_pulse` and array read mode. Repeated B0h writes while suspended, and 30h writes while erasing, are ignored. 30h while suspended gives `resume_pulse` and returns to erase. If the erase had not started yet, `erase_req` is raised in the same cycle. Several rounds are allowed.
- R7: While suspended, the full program sequence is accepted and the decoder returns to the suspended state on `alg_done`. A program whose address lies in a sector of the erase mask is dropped without a request.
- R8: 555h/AAh, 2AAh/55h, 555h/20h enters bypass mode (`bypass_mode`=1). In bypass mode, A0h at any address followed by an address and data raises `prog_req`. Other writes are ignored. Data 90h followed by data 00h leaves bypass mode.
- R9: 555h/AAh, 2AAh/55h, 555h/90h selects identifier mode (`rd_sel`=1). Within a sector, offset 0 reads 0052h, offset 1 reads the device code 22BAh, and offset 2 reads the protection bit of the addressed sector on bit 0. Data F0h returns to array read.
- R10: Writes made while a program is running produce no request and leave `rd_sel` at status.
- R11: Reset forces array read, leaves bypass mode, closes the window and aborts any running operation, so no request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data, command code in the low byte |
| rd_addr | input | ADDR_W | Current read address, used in identifier mode |
| prot_mask | input | 2**SECT_BITS | Per-sector protection flags |
| alg_done | input | 1 | One-cycle end of a program or erase algorithm |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_data | output | 16 | Identifier word for rd_addr |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | 16 | Latched program data |
| erase_req | output | 1 | One-cycle erase start request |
| erase_chip | output | 1 | Erase in progress covers the whole chip |
| erase_mask | output | 2**SECT_BITS | Sectors selected for erase |
| suspend_pulse | output | 1 | One-cycle erase suspend |
| resume_pulse | output | 1 | One-cycle erase resume |
| bypass_mode | output | 1 | Bypass program mode active |
| window_open | output | 1 | Multi-sector acceptance window open |

## Verification
The bench builds the decoder with `ADDR_W`=18, `SECT_BITS`=3 (eight sectors of 32K words) and `WIN_CYC`=16. The short window lets a test watch it expire, restart it partway through so that the total wait exceeds one window, and cancel it, all within a few dozen cycles. Eight sectors give room to mix two erase targets, a program into a sector that is not being erased, a program into an erasing sector, and protected and unprotected identifier reads.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_ID     = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_U1,
    S_U2,
    S_PSETUP,
    S_E1,
    S_E2,
    S_E3,
    S_ID,
    S_BYP,
    S_BYP_PS,
    S_BYP_RST,
    S_PROG,
    S_WIN,
    S_ERASE,
    S_SUSP
  } dec_state_e;

  localparam logic [10:0] ADR_A = 11'h555;
  localparam logic [10:0] ADR_B = 11'h2AA;

  localparam logic [7:0] CMD_UNLK1   = 8'hAA;
  localparam logic [7:0] CMD_UNLK2   = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_BYPEXIT = 8'h00;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  function automatic logic cyc_match(input logic [10:0] a, input logic [7:0] d,
                                     input logic [10:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic rd_sel_e sel_of_state(input dec_state_e s);
    case (s)
      S_ID:                    return RD_ID;
      S_PROG, S_WIN, S_ERASE:  return RD_STATUS;
      default:                 return RD_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nfc_sector_dec.sv
module nfc_sector_dec #(
  parameter int SECT_BITS = 3,
  localparam int NSECT = 1 << SECT_BITS
) (
  input  logic [SECT_BITS-1:0] sel,
  output logic [NSECT-1:0]     hot
);
  for (genvar g = 0; g < NSECT; g++) begin : g_dec
    localparam logic [SECT_BITS-1:0] IDX = SECT_BITS'(g);
    assign hot[g] = (sel == IDX);
  end
endmodule

// File: rtl/nfc_erase_window.sv
module nfc_erase_window #(
  parameter int WIN_CYC = 5000,
  localparam int CNT_W = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic stop,
  output logic open_o,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = open_o && (cnt_q == LAST) && !restart && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (restart) begin
      open_o <= 1'b1;
      cnt_q  <= '0;
    end else if (stop) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (open_o) begin
      if (cnt_q == LAST) begin
        open_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: an expiry always closes the window on the next cycle
  p_expire_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !open_o);

  // R5: a restart always leaves the window open
  p_restart_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> open_o);

endmodule

// File: rtl/nfc_id_mux.sv
module nfc_id_mux #(
  parameter int          ADDR_W    = 18,
  parameter int          SECT_BITS = 3,
  parameter logic [15:0] MFR_CODE  = 16'h0052,
  parameter logic [15:0] DEV_CODE  = 16'h22BA,
  localparam int NSECT = 1 << SECT_BITS,
  localparam int OFS_W = ADDR_W - SECT_BITS
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  prot_mask,
  output logic [15:0]       id_data
);
  logic [NSECT-1:0] rd_hot;
  logic [OFS_W-1:0] ofs;
  logic             prot_bit;

  nfc_sector_dec #(.SECT_BITS(SECT_BITS)) u_rd_dec (
    .sel (rd_addr[ADDR_W-1 -: SECT_BITS]),
    .hot (rd_hot)
  );

  assign ofs      = rd_addr[OFS_W-1:0];
  assign prot_bit = |(rd_hot & prot_mask);

  always_comb begin
    if (ofs == OFS_W'(0))      id_data = MFR_CODE;
    else if (ofs == OFS_W'(1)) id_data = DEV_CODE;
    else if (ofs == OFS_W'(2)) id_data = {15'd0, prot_bit};
    else                       id_data = 16'd0;
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int ADDR_W    = 18,
  parameter int SECT_BITS = 3,
  parameter int WIN_CYC   = 5000,
  localparam int NSECT = 1 << SECT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic              alg_done,
  output logic [1:0]        rd_sel,
  output logic [15:0]       id_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [NSECT-1:0]  erase_mask,
  output logic              suspend_pulse,
  output logic              resume_pulse,
  output logic              bypass_mode,
  output logic              window_open
);
  import nfc_pkg::*;

  dec_state_e       state_q;
  logic             in_susp_q;
  logic             started_q;
  logic [NSECT-1:0] wr_hot;
  logic [10:0]      a11;
  logic [7:0]       d8;
  logic             c_unlk1, c_unlk2, c_setup;
  logic             win_restart, win_stop, win_expire;
  dec_state_e       base_st, ret_st;

  assign a11 = wr_addr[10:0];
  assign d8  = wr_data[7:0];

  assign c_unlk1 = cyc_match(a11, d8, ADR_A, CMD_UNLK1);
  assign c_unlk2 = cyc_match(a11, d8, ADR_B, CMD_UNLK2);
  assign c_setup = (a11 == ADR_A);

  assign base_st = in_susp_q ? S_SUSP : S_IDLE;
  assign ret_st  = bypass_mode ? S_BYP : base_st;

  nfc_sector_dec #(.SECT_BITS(SECT_BITS)) u_wr_dec (
    .sel (wr_addr[ADDR_W-1 -: SECT_BITS]),
    .hot (wr_hot)
  );

  assign win_restart = wr_en && (d8 == CMD_SECTOR) &&
                       (state_q == S_E3 || state_q == S_WIN);
  assign win_stop    = wr_en && (d8 != CMD_SECTOR) && (state_q == S_WIN);

  nfc_erase_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (win_restart),
    .stop     (win_stop),
    .open_o   (window_open),
    .expire_o (win_expire)
  );

  nfc_id_mux #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_id (
    .rd_addr   (rd_addr),
    .prot_mask (prot_mask),
    .id_data   (id_data)
  );

  assign rd_sel = sel_of_state(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      in_susp_q     <= 1'b0;
      started_q     <= 1'b0;
      bypass_mode   <= 1'b0;
      prog_req      <= 1'b0;
      prog_addr     <= '0;
      prog_data     <= '0;
      erase_req     <= 1'b0;
      erase_chip    <= 1'b0;
      erase_mask    <= '0;
      suspend_pulse <= 1'b0;
      resume_pulse  <= 1'b0;
    end else begin
      prog_req      <= 1'b0;
      erase_req     <= 1'b0;
      suspend_pulse <= 1'b0;
      resume_pulse  <= 1'b0;
      case (state_q)
        S_IDLE: if (wr_en && c_unlk1) state_q <= S_U1;
        S_U1: if (wr_en) state_q <= c_unlk2 ? S_U2 : base_st;
        S_U2: if (wr_en) begin
          if (c_setup && d8 == CMD_PROG) state_q <= S_PSETUP;
          else if (!in_susp_q && c_setup && d8 == CMD_ERSETUP) state_q <= S_E1;
          else if (!in_susp_q && c_setup && d8 == CMD_IDENT) state_q <= S_ID;
          else if (!in_susp_q && c_setup && d8 == CMD_BYPASS) begin
            state_q     <= S_BYP;
            bypass_mode <= 1'b1;
          end else state_q <= base_st;
        end
        S_PSETUP, S_BYP_PS: if (wr_en) begin
          if (in_susp_q && |(wr_hot & erase_mask)) begin
            state_q <= base_st;
          end else begin
            prog_req  <= 1'b1;
            prog_addr <= wr_addr;
            prog_data <= wr_data;
            state_q   <= S_PROG;
          end
        end
        S_PROG: if (alg_done) state_q <= ret_st;
        S_E1: if (wr_en) state_q <= c_unlk1 ? S_E2 : S_IDLE;
        S_E2: if (wr_en) state_q <= c_unlk2 ? S_E3 : S_IDLE;
        S_E3: if (wr_en) begin
          if (d8 == CMD_SECTOR) begin
            erase_mask <= wr_hot;
            erase_chip <= 1'b0;
            state_q    <= S_WIN;
          end else if (d8 == CMD_CHIP) begin
            erase_mask <= '1;
            erase_chip <= 1'b1;
            erase_req  <= 1'b1;
            started_q  <= 1'b1;
            state_q    <= S_ERASE;
          end else state_q <= S_IDLE;
        end
        S_WIN: begin
          if (wr_en) begin
            if (d8 == CMD_SECTOR) begin
              erase_mask <= erase_mask | wr_hot;
            end else if (d8 == CMD_SUSPEND) begin
              suspend_pulse <= 1'b1;
              in_susp_q     <= 1'b1;
              state_q       <= S_SUSP;
            end else begin
              erase_mask <= '0;
              state_q    <= S_IDLE;
            end
          end else if (win_expire) begin
            erase_req <= 1'b1;
            started_q <= 1'b1;
            state_q   <= S_ERASE;
          end
        end
        S_ERASE: begin
          if (alg_done) begin
            erase_mask <= '0;
            erase_chip <= 1'b0;
            started_q  <= 1'b0;
            state_q    <= S_IDLE;
          end else if (wr_en && d8 == CMD_SUSPEND && !erase_chip) begin
            suspend_pulse <= 1'b1;
            in_susp_q     <= 1'b1;
            state_q       <= S_SUSP;
          end
        end
        S_SUSP: if (wr_en) begin
          if (d8 == CMD_SECTOR) begin
            resume_pulse <= 1'b1;
            in_susp_q    <= 1'b0;
            state_q      <= S_ERASE;
            if (!started_q) begin
              erase_req <= 1'b1;
              started_q <= 1'b1;
            end
          end else if (c_unlk1) state_q <= S_U1;
        end
        S_ID: if (wr_en && d8 == CMD_RESET) state_q <= S_IDLE;
        S_BYP: if (wr_en) begin
          if (d8 == CMD_PROG) state_q <= S_BYP_PS;
          else if (d8 == CMD_IDENT) state_q <= S_BYP_RST;
        end
        S_BYP_RST: if (wr_en) begin
          if (d8 == CMD_BYPEXIT) begin
            bypass_mode <= 1'b0;
            state_q     <= S_IDLE;
          end else state_q <= S_BYP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: a program request only ever follows a bus write
  p_prog_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(wr_en));

  // R1: status is selected while a program request is issued
  p_prog_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (rd_sel == 2'd2));

  // R10: writes during a running program raise nothing
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG && !alg_done) |=>
      !prog_req && !erase_req && !suspend_pulse && !resume_pulse);

  // R3: an erase request always names at least one sector
  p_erase_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (erase_mask != '0));

  // R4: a chip erase covers every sector
  p_chip_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_chip) |-> (&erase_mask));

  // R6: program, suspend and resume pulses never coincide
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, suspend_pulse, resume_pulse}));

  // R6: a suspend hands the bus back to array reads
  p_suspend_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> (rd_sel == 2'd0) && !window_open);

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;
  localparam int AW = 18;
  localparam int SB = 3;
  localparam int NS = 1 << SB;
  localparam int WIN = 16;

  localparam int K_PROG = 1, K_ERASE = 2, K_SUSP = 3, K_RES = 4;

  typedef struct {
    int          kind;
    logic [AW-1:0] addr;
    logic [15:0] data;
    logic [NS-1:0] mask;
    logic        chip;
    string       tag;
  } ev_t;

  logic clk = 0, rst_n = 0, wr_en = 0, alg_done = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NS-1:0] prot_mask = 8'b0000_1000;
  logic [1:0] rd_sel;
  logic [15:0] id_data, prog_data;
  logic prog_req, erase_req, erase_chip, suspend_pulse, resume_pulse, bypass_mode, window_open;
  logic [AW-1:0] prog_addr;
  logic [NS-1:0] erase_mask;

  int checks = 0, errors = 0;
  int cycles = 0;
  bit done_flag = 0;
  ev_t expq[$];

  always #2 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(AW), .SECT_BITS(SB), .WIN_CYC(WIN)) u_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prot_mask(prot_mask), .alg_done(alg_done),
    .rd_sel(rd_sel), .id_data(id_data), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_chip(erase_chip),
    .erase_mask(erase_mask), .suspend_pulse(suspend_pulse), .resume_pulse(resume_pulse),
    .bypass_mode(bypass_mode), .window_open(window_open));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sect(input int s, input int ofs);
    return AW'((s << (AW - SB)) + ofs);
  endfunction

  task automatic push(input int k, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [NS-1:0] m, input logic c, input string tag);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.mask = m; e.chip = c; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); alg_done = 1;
    @(negedge clk); alg_done = 0;
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
  endtask

  task automatic unlock();
    wr(18'h00555, 16'h00AA);
    wr(18'h002AA, 16'h0055);
  endtask

  task automatic six(input logic [AW-1:0] a, input logic [7:0] last);
    unlock();
    wr(18'h00555, 16'h0080);
    unlock();
    wr(a, {8'h00, last});
  endtask

  task automatic match(input int k, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [NS-1:0] m, input logic c);
    ev_t e;
    if (expq.size() == 0) begin
      chk(0, $sformatf("unexpected event kind %0d (R2 R10 R5)", k), 32'(k), 32'd0);
    end else begin
      e = expq.pop_front();
      chk(e.kind == k, {e.tag, " kind"}, 32'(k), 32'(e.kind));
      if (k == K_PROG) begin
        chk(a == e.addr, {e.tag, " addr"}, 32'(a), 32'(e.addr));
        chk(d == e.data, {e.tag, " data"}, 32'(d), 32'(e.data));
      end
      if (k == K_ERASE) begin
        chk(m == e.mask, {e.tag, " mask"}, 32'(m), 32'(e.mask));
        chk(c == e.chip, {e.tag, " chip"}, 32'(c), 32'(e.chip));
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (resume_pulse)  match(K_RES, '0, '0, '0, 1'b0);
      if (erase_req)     match(K_ERASE, '0, '0, erase_mask, erase_chip);
      if (prog_req)      match(K_PROG, prog_addr, prog_data, '0, 1'b0);
      if (suspend_pulse) match(K_SUSP, '0, '0, '0, 1'b0);
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      chk(expq.size() == 0, "scoreboard drained", 32'(expq.size()), 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", 32'(cycles), 32'd150000);
      finish_run();
    end
  end

  initial begin
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(rd_sel == 2'd0, "R11 reset rd_sel", 32'(rd_sel), 32'd0);
    chk(!bypass_mode && !window_open, "R11 reset flags", {30'd0, bypass_mode, window_open}, 32'd0);

    // R1 standard program
    unlock();
    wr(18'h00555, 16'h00A0);
    push(K_PROG, 18'h12345, 16'hBEEF, '0, 0, "R1 program");
    wr(18'h12345, 16'hBEEF);
    chk(rd_sel == 2'd2, "R1 status while busy", 32'(rd_sel), 32'd2);
    // R10 writes during program ignored
    unlock();
    wr(18'h00555, 16'h00A0);
    wr(18'h00100, 16'h1111);
    wr(18'h00555, 16'h00B0);
    chk(rd_sel == 2'd2, "R10 still status", 32'(rd_sel), 32'd2);
    done_pulse();
    chk(rd_sel == 2'd0, "R1 array after done", 32'(rd_sel), 32'd0);

    // R2 bad unlock cycles
    wr(18'h00555, 16'h00AA);
    wr(18'h002AB, 16'h0055);
    wr(18'h00555, 16'h00A0);
    wr(18'h00200, 16'h2222);
    chk(rd_sel == 2'd0, "R2 bad address idle", 32'(rd_sel), 32'd0);
    unlock();
    wr(18'h00555, 16'h00A1);
    wr(18'h00200, 16'h2222);
    chk(rd_sel == 2'd0, "R2 bad data idle", 32'(rd_sel), 32'd0);
    unlock();
    wr(18'h00555, 16'h00A0);
    push(K_PROG, 18'h00300, 16'h3333, '0, 0, "R2 recovers");
    wr(18'h00300, 16'h3333);
    done_pulse();

    // R9 identifier mode
    unlock();
    wr(18'h00555, 16'h0090);
    chk(rd_sel == 2'd1, "R9 id select", 32'(rd_sel), 32'd1);
    rd_addr = sect(3, 0); #1;
    chk(id_data == 16'h0052, "R9 mfr code", 32'(id_data), 32'h52);
    rd_addr = sect(3, 1); #1;
    chk(id_data == 16'h22BA, "R9 device code", 32'(id_data), 32'h22BA);
    rd_addr = sect(3, 2); #1;
    chk(id_data == 16'h0001, "R9 protected", 32'(id_data), 32'h1);
    rd_addr = sect(2, 2); #1;
    chk(id_data == 16'h0000, "R9 unprotected", 32'(id_data), 32'h0);
    wr(18'h00000, 16'h00F0);
    chk(rd_sel == 2'd0, "R9 exit", 32'(rd_sel), 32'd0);

    // R3 sector erase with window expiry
    six(sect(5, 7), 8'h30);
    chk(window_open && rd_sel == 2'd2, "R3 window opens", {30'd0, rd_sel}, 32'd2);
    idle(8);
    chk(window_open, "R3 still open midway", 32'(window_open), 32'd1);
    push(K_ERASE, '0, '0, 8'h20, 0, "R3 erase start");
    idle(12);
    chk(!window_open && rd_sel == 2'd2, "R3 window closed, erasing", {31'd0, window_open}, 32'd0);
    done_pulse();
    chk(rd_sel == 2'd0, "R3 done array", 32'(rd_sel), 32'd0);

    // R5 multi-sector with restart
    six(sect(1, 0), 8'h30);
    idle(9);
    wr(sect(6, 4), 16'h0030);
    idle(9);
    chk(window_open, "R5 restart keeps window", 32'(window_open), 32'd1);
    push(K_ERASE, '0, '0, 8'h42, 0, "R5 merged mask");
    idle(12);
    done_pulse();
    // R5 cancel
    six(sect(2, 0), 8'h30);
    wr(18'h00000, 16'h00F0);
    chk(!window_open && rd_sel == 2'd0, "R5 cancel", {30'd0, rd_sel}, 32'd0);
    idle(WIN + 4);

    // R4 chip erase
    push(K_ERASE, '0, '0, 8'hFF, 1, "R4 chip erase");
    six(18'h00555, 8'h10);
    chk(rd_sel == 2'd2, "R4 status", 32'(rd_sel), 32'd2);
    wr(18'h00000, 16'h00B0);
    chk(rd_sel == 2'd2, "R4 suspend ignored", 32'(rd_sel), 32'd2);
    done_pulse();

    // R6 suspend during window
    six(sect(4, 0), 8'h30);
    push(K_SUSP, '0, '0, '0, 0, "R6 suspend in window");
    wr(18'h00000, 16'h00B0);
    chk(rd_sel == 2'd0 && !window_open, "R6 array after suspend", {30'd0, rd_sel}, 32'd0);
    wr(18'h00000, 16'h00B0);
    idle(WIN + 2);
    // R7 program while suspended
    unlock();
    wr(18'h00555, 16'h00A0);
    push(K_PROG, 18'h00010, 16'hCAFE, '0, 0, "R7 suspended program");
    wr(18'h00010, 16'hCAFE);
    chk(rd_sel == 2'd2, "R7 status", 32'(rd_sel), 32'd2);
    done_pulse();
    chk(rd_sel == 2'd0, "R7 back to suspended", 32'(rd_sel), 32'd0);
    unlock();
    wr(18'h00555, 16'h00A0);
    wr(sect(4, 9), 16'h1234);
    chk(rd_sel == 2'd0, "R7 erasing-sector program dropped", 32'(rd_sel), 32'd0);
    push(K_RES, '0, '0, '0, 0, "R6 resume");
    push(K_ERASE, '0, '0, 8'h10, 0, "R6 deferred erase start");
    wr(18'h00000, 16'h0030);
    chk(rd_sel == 2'd2, "R6 erasing after resume", 32'(rd_sel), 32'd2);
    wr(18'h00000, 16'h0030);
    push(K_SUSP, '0, '0, '0, 0, "R6 second suspend");
    wr(18'h00000, 16'h00B0);
    push(K_RES, '0, '0, '0, 0, "R6 second resume");
    wr(18'h00000, 16'h0030);
    done_pulse();
    chk(rd_sel == 2'd0, "R6 erase complete", 32'(rd_sel), 32'd0);

    // R8 bypass mode
    unlock();
    wr(18'h00555, 16'h0020);
    chk(bypass_mode, "R8 enter bypass", 32'(bypass_mode), 32'd1);
    wr(18'h03000, 16'h00A0);
    push(K_PROG, 18'h01234, 16'h5A5A, '0, 0, "R8 bypass program");
    wr(18'h01234, 16'h5A5A);
    done_pulse();
    chk(bypass_mode && rd_sel == 2'd0, "R8 stays bypass", {30'd0, bypass_mode, rd_sel[1]}, 32'd2);
    wr(18'h00555, 16'h0080);
    wr(18'h00555, 16'h00F0);
    chk(bypass_mode, "R8 other writes ignored", 32'(bypass_mode), 32'd1);
    wr(18'h00000, 16'h0090);
    wr(18'h00000, 16'h0000);
    chk(!bypass_mode, "R8 exit bypass", 32'(bypass_mode), 32'd0);
    wr(18'h00000, 16'h00A0);
    wr(18'h00400, 16'h4444);
    chk(rd_sel == 2'd0, "R8 no program after exit", 32'(rd_sel), 32'd0);

    // R11 reset aborts
    unlock();
    wr(18'h00555, 16'h00A0);
    push(K_PROG, 18'h00500, 16'h5555, '0, 0, "R11 program before reset");
    wr(18'h00500, 16'h5555);
    hw_reset();
    @(negedge clk);
    chk(rd_sel == 2'd0, "R11 reset aborts program", 32'(rd_sel), 32'd0);
    unlock();
    wr(18'h00555, 16'h0020);
    six(sect(7, 0), 8'h30);
    hw_reset();
    @(negedge clk);
    chk(!bypass_mode && !window_open, "R11 reset clears modes", {30'd0, bypass_mode, window_open}, 32'd0);
    idle(WIN + 4);

    finish_run();
  end
endmodule